// File: doc/BRIEF.md
# Random-Delay Anti-Collision Scheduler

This block is the control core of a passive identification tag that shares a reader field with many other tags. It waits a pseudo-random number of bit periods, then asks the transmit path to send the stored identifier. After each transmission it draws a new random value and starts a new wait. Because every tag waits a different amount of time, replies from a crowd of tags rarely collide.

Events from a gap classifier change this free-running behaviour. An acknowledge that arrives in the short listen window after a reply either switches the tag off or slows its counting. A mute puts the tag to sleep for a fixed number of bit periods. A wake-up ends that sleep early. A configuration word and a seed are captured once, when reset is released.

Top module: `tag_slot_scheduler`

## Requirements
- R1: While `rst` is high, `tx_req`, `asleep`, `tag_off` and `test_mode` are low. On the first clock edge after reset is released, the block captures `seed`, `cfg_word` and `test_sel`.
- R2: `cfg_word[2:0]` selects a compare width of CMP_MIN+sel bits. A 16-bit counter advances on each `bit_en`. When its low bits equal the same bits of the random value v, `tx_req` rises. With `bit_en` held high, this happens v+2 clock edges after reset release.
- R3: The edge that accepts `tx_done` steps the random generator, clears the counter and opens a listen window of ACK_WIN clocks. With `bit_en` held high, the next `tx_req` follows v+ACK_WIN+2 edges after the accept edge. The generator is a right-shifting Galois LFSR: when bit 0 is set, the shifted value is XORed with 0xB400.
- R4: A zero seed is replaced by 0xACE1, so the random value is never zero.
- R5: If `test_sel` is high at capture, `test_mode` goes high and `tx_req` is never raised.
- R6: An acknowledge received inside the listen window, with `cfg_word[3]`=1 and `cfg_word[5]`=0, makes the counter advance only on every 8th `bit_en`. This lasts until reset.
- R7: An acknowledge received inside the listen window, with `cfg_word[3]`=1 and `cfg_word[5]`=1, raises `tag_off`. No further `tx_req` follows.
- R8: A mute with `cfg_word[4]`=1, received while not transmitting, raises `asleep` for SLEEP_LEN `bit_en` periods. The counter is frozen during the sleep. With `bit_en` held high, a mute on the first listen clock gives a delay of v+SLEEP_LEN+3 edges from the accept edge.
- R9: A mute during sleep restarts the full sleep period. A wake-up during sleep returns to counting on that edge. Wake-up wins over a simultaneous mute.
- R10: A mute is ignored while `cfg_word[4]`=0 or while `tx_req` is high. An acknowledge is ignored while `cfg_word[3]`=0.
- R11: `tx_req` stays high until `tx_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate clock enable |
| test_sel | input | 1 | Test mode select, captured at boot |
| cfg_word | input | 6 | [2:0] span select, [3] ack enable, [4] mute enable, [5] ack switches off |
| seed | input | 16 | Random generator seed, captured at boot |
| ack_evt | input | 1 | Acknowledge strobe from the gap classifier |
| mute_evt | input | 1 | Mute strobe from the gap classifier |
| wake_evt | input | 1 | Wake-up strobe from the gap classifier |
| tx_done | input | 1 | Transmit path finished sending the identifier |
| tx_req | output | 1 | Request to transmit the identifier |
| test_mode | output | 1 | Block is parked in test mode |
| asleep | output | 1 | Block is in the timed sleep |
| tag_off | output | 1 | Block has been switched off by an acknowledge |

## Verification
The main delay path is swept over all eight span selects, using a zero seed, a sparse seed and an all-ones seed. Four consecutive delays are measured per run. This separates a wrong compare mask, a wrong LFSR step and a failure to substitute the zero seed, since each shifts the measured cycle counts away from the arithmetic model.

Listen-window acknowledges are tried both with the slow-down action and with the switch-off action. Multiplying by eight separates the slow-down mode from plain counting. Mute is tried:
- alone, to check the sleep length;
- repeated during sleep, to check the restart;
- followed by a wake-up, to check the early exit;
- with mute disabled;
- during a transmission.

Each case has its own expected delay, so it can be told apart from the others.

// File: rtl/tag_sched_pkg.sv
package tag_sched_pkg;

    localparam int RND_W        = 16;
    localparam int SEL_W        = 3;
    localparam int CFG_W        = 6;
    localparam logic [RND_W-1:0] RND_TAPS     = 16'hB400;
    localparam logic [RND_W-1:0] RND_ZERO_SUB = 16'hACE1;

    typedef struct packed {
        logic             ack_kills;
        logic             mute_en;
        logic             ack_en;
        logic [SEL_W-1:0] span_sel;
    } sched_cfg_t;

    typedef enum logic [2:0] {
        ST_BOOT  = 3'd0,
        ST_RUN   = 3'd1,
        ST_TX    = 3'd2,
        ST_POST  = 3'd3,
        ST_SLEEP = 3'd4,
        ST_OFF   = 3'd5,
        ST_TEST  = 3'd6
    } sched_st_t;

    function automatic logic [RND_W-1:0] rnd_next(input logic [RND_W-1:0] x);
        logic [RND_W-1:0] sh;
        sh = x >> 1;
        return x[0] ? (sh ^ RND_TAPS) : sh;
    endfunction

    function automatic logic [RND_W-1:0] seed_fix(input logic [RND_W-1:0] x);
        return (x == '0) ? RND_ZERO_SUB : x;
    endfunction

    function automatic logic [RND_W-1:0] span_mask(input logic [SEL_W-1:0] sel,
                                                  input int cmp_min);
        logic [RND_W-1:0] m;
        for (int i = 0; i < RND_W; i++) begin
            m[i] = (i < (cmp_min + int'(sel)));
        end
        return m;
    endfunction

endpackage

// File: rtl/slot_prng.sv
module slot_prng
    import tag_sched_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [RND_W-1:0] seed,
    input  logic             step,
    output logic [RND_W-1:0] value
);

    logic [RND_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RND_ZERO_SUB;
        end else if (load) begin
            state_q <= seed_fix(seed);
        end else if (step) begin
            state_q <= rnd_next(state_q);
        end
    end

    assign value = state_q;

    // R4: the generator never holds the all-zero value
    a_r4_never_zero: assert property (@(posedge clk) disable iff (rst)
        value != '0);

    // R3: value only moves on a load or a step
    a_r3_value_hold: assert property (@(posedge clk) disable iff (rst)
        !load && !step |=> $stable(value));

endmodule

// File: rtl/delay_matcher.sv
module delay_matcher
    import tag_sched_pkg::*;
#(
    parameter int CMP_MIN  = 9,
    parameter int SLOW_DIV = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic             bit_en,
    input  logic             slow,
    input  logic [SEL_W-1:0] span_sel,
    input  logic [RND_W-1:0] rnd,
    output logic             hit
);

    localparam int DW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(SLOW_DIV - 1);

    logic [RND_W-1:0] cnt_q;
    logic [RND_W-1:0] mask;
    logic [DW-1:0]    div_q;
    logic             adv;
    logic             tick;

    always_comb begin
        mask = span_mask(span_sel, CMP_MIN);
        hit  = ((cnt_q ^ rnd) & mask) == '0;
        adv  = run && !hit && bit_en;
        tick = adv && (!slow || (div_q == DIV_LAST));
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
            div_q <= '0;
        end else begin
            if (adv && slow) begin
                div_q <= div_q + 1'b1;
            end
            if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R8: count is frozen whenever counting is suspended
    a_r8_count_frozen: assert property (@(posedge clk) disable iff (rst)
        !run && !clear |=> $stable(cnt_q));

    // R6: in slow mode the count never moves on consecutive edges
    a_r6_slow_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        slow && !clear && $changed(cnt_q) |=> $stable(cnt_q) || clear);

endmodule

// File: rtl/sleep_timer.sv
module sleep_timer #(
    parameter int SLEEP_LEN = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    input  logic bit_en,
    output logic expired
);

    localparam int CW = $clog2(SLEEP_LEN) + 1;
    localparam logic [CW-1:0] LAST = CW'(SLEEP_LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt_q <= '0;
        end else if (active && bit_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = active && bit_en && (cnt_q == LAST);

    // R8: the sleep count never runs past its period
    a_r8_sleep_bounded: assert property (@(posedge clk) disable iff (rst)
        active |-> cnt_q <= LAST);

endmodule

// File: rtl/tag_slot_scheduler.sv
module tag_slot_scheduler
    import tag_sched_pkg::*;
#(
    parameter int CMP_MIN   = 9,
    parameter int ACK_WIN   = 4,
    parameter int SLEEP_LEN = 128,
    parameter int SLOW_DIV  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             test_sel,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic [RND_W-1:0] seed,
    input  logic             ack_evt,
    input  logic             mute_evt,
    input  logic             wake_evt,
    input  logic             tx_done,
    output logic             tx_req,
    output logic             test_mode,
    output logic             asleep,
    output logic             tag_off
);

    localparam int PW = $clog2(ACK_WIN) + 1;
    localparam logic [PW-1:0] POST_LAST = PW'(ACK_WIN - 1);

    sched_st_t        state_q;
    sched_cfg_t       cfg_q;
    logic             slow_q;
    logic [PW-1:0]    post_q;
    logic [RND_W-1:0] rnd;
    logic             hit;
    logic             boot;
    logic             accept;
    logic             mute_ok;
    logic             ack_ok;
    logic             run_cnt;
    logic             sleep_start;
    logic             sleep_done;

    always_comb begin
        boot    = (state_q == ST_BOOT);
        accept  = (state_q == ST_TX) && tx_done;
        mute_ok = cfg_q.mute_en && mute_evt &&
                  ((state_q == ST_RUN) || (state_q == ST_POST) || (state_q == ST_SLEEP));
        ack_ok  = cfg_q.ack_en && ack_evt && (state_q == ST_POST);
        run_cnt = (state_q == ST_RUN) && !mute_ok;
        sleep_start = mute_ok && !(state_q == ST_SLEEP && wake_evt)
                      && !(ack_ok && cfg_q.ack_kills);
    end

    slot_prng u_prng (
        .clk   (clk),
        .rst   (rst),
        .load  (boot),
        .seed  (seed),
        .step  (accept),
        .value (rnd)
    );

    delay_matcher #(
        .CMP_MIN  (CMP_MIN),
        .SLOW_DIV (SLOW_DIV)
    ) u_match (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .run      (run_cnt),
        .bit_en   (bit_en),
        .slow     (slow_q),
        .span_sel (cfg_q.span_sel),
        .rnd      (rnd),
        .hit      (hit)
    );

    sleep_timer #(
        .SLEEP_LEN (SLEEP_LEN)
    ) u_sleep (
        .clk     (clk),
        .rst     (rst),
        .start   (sleep_start),
        .active  (state_q == ST_SLEEP),
        .bit_en  (bit_en),
        .expired (sleep_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BOOT;
            cfg_q   <= '0;
            slow_q  <= 1'b0;
            post_q  <= '0;
        end else begin
            unique case (state_q)
                ST_BOOT: begin
                    cfg_q   <= sched_cfg_t'(cfg_word);
                    state_q <= test_sel ? ST_TEST : ST_RUN;
                end
                ST_RUN: begin
                    if (mute_ok) begin
                        state_q <= ST_SLEEP;
                    end else if (hit) begin
                        state_q <= ST_TX;
                    end
                end
                ST_TX: begin
                    if (tx_done) begin
                        state_q <= ST_POST;
                        post_q  <= '0;
                    end
                end
                ST_POST: begin
                    if (ack_ok && cfg_q.ack_kills) begin
                        state_q <= ST_OFF;
                    end else if (!ack_ok && mute_ok) begin
                        state_q <= ST_SLEEP;
                    end else begin
                        if (ack_ok) begin
                            slow_q <= 1'b1;
                        end
                        post_q <= post_q + 1'b1;
                        if (post_q == POST_LAST) begin
                            state_q <= ST_RUN;
                        end
                    end
                end
                ST_SLEEP: begin
                    if (wake_evt || (!mute_ok && sleep_done)) begin
                        state_q <= ST_RUN;
                    end
                end
                ST_OFF:  state_q <= ST_OFF;
                ST_TEST: state_q <= ST_TEST;
                default: state_q <= ST_BOOT;
            endcase
        end
    end

    always_comb begin
        tx_req    = (state_q == ST_TX);
        test_mode = (state_q == ST_TEST);
        asleep    = (state_q == ST_SLEEP);
        tag_off   = (state_q == ST_OFF);
    end

    // R11: a request is held until the transmit path reports done
    a_r11_req_held: assert property (@(posedge clk) disable iff (rst)
        tx_req && !tx_done |=> tx_req);

    // R7: switch-off is permanent until reset
    a_r7_off_sticky: assert property (@(posedge clk) disable iff (rst)
        tag_off |=> tag_off && !tx_req);

    // R10: a mute during a transmission does not start a sleep
    a_r10_no_sleep_in_tx: assert property (@(posedge clk) disable iff (rst)
        tx_req && !tx_done |=> !asleep);

    // R6: slow mode stays until reset
    a_r6_slow_sticky: assert property (@(posedge clk) disable iff (rst)
        slow_q |=> slow_q);

    // R1: captured configuration never changes after boot
    a_r1_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        !boot |=> $stable(cfg_q));

    // R5: test mode never requests a transmission
    a_r5_test_parked: assert property (@(posedge clk) disable iff (rst)
        test_mode |=> test_mode && !tx_req);

endmodule

// File: tb/tag_slot_scheduler_test.sv
`timescale 1ns/1ps
module tag_slot_scheduler_test;

    localparam int CMP_MIN   = 2;
    localparam int ACK_WIN   = 4;
    localparam int SLEEP_LEN = 16;
    localparam int LIM       = 6000;
    localparam int WD        = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b1;
    logic        test_sel = 1'b0;
    logic [5:0]  cfg_word = '0;
    logic [15:0] seed = '0;
    logic        ack_evt = 1'b0;
    logic        mute_evt = 1'b0;
    logic        wake_evt = 1'b0;
    logic        tx_done = 1'b0;
    logic        tx_req, test_mode, asleep, tag_off;

    int checks = 0;
    int errs   = 0;
    int cyc    = 0;
    bit fin    = 1'b0;

    logic [15:0] r;
    int          msk;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tag_slot_scheduler #(
        .CMP_MIN   (CMP_MIN),
        .ACK_WIN   (ACK_WIN),
        .SLEEP_LEN (SLEEP_LEN),
        .SLOW_DIV  (8)
    ) uut (
        .clk (clk), .rst (rst), .bit_en (bit_en), .test_sel (test_sel),
        .cfg_word (cfg_word), .seed (seed), .ack_evt (ack_evt),
        .mute_evt (mute_evt), .wake_evt (wake_evt), .tx_done (tx_done),
        .tx_req (tx_req), .test_mode (test_mode), .asleep (asleep),
        .tag_off (tag_off)
    );

    function automatic logic [15:0] m_next(input logic [15:0] x);
        return x[0] ? ((x >> 1) ^ 16'hB400) : (x >> 1);
    endfunction

    function automatic int cur_v();
        return int'(r) & msk;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start(input logic [15:0] sd, input int sel, input bit ae,
                         input bit me, input bit kill, input bit ts, output int t0);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        seed     = sd;
        cfg_word = {kill, me, ae, 3'(sel)};
        test_sel = ts;
        rst      = 1'b0;
        t0       = cyc;
        r        = (sd == 16'h0) ? 16'hACE1 : sd;
        msk      = (1 << (CMP_MIN + sel)) - 1;
    endtask

    task automatic wait_req(input int t0, output int n);
        while (!tx_req && (cyc - t0) < LIM) @(negedge clk);
        n = cyc - t0;
    endtask

    // drive tx_done for one edge; step the model
    task automatic done_edge(output int t0);
        t0 = cyc;
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        r = m_next(r);
    endtask

    always @(posedge clk) begin
        if (cyc > WD && !fin) begin
            fin = 1'b1;
            checks++;
            errs++;
            $display("FAIL R2 watchdog actual=%0d expected<%0d", cyc, WD);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, errs);
            $finish;
        end
    end

    initial begin
        int t0, n, e;
        logic [15:0] seeds [3];
        seeds[0] = 16'h0000; seeds[1] = 16'h1234; seeds[2] = 16'hFFFF;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!tx_req && !asleep && !tag_off && !test_mode, "R1 reset outputs",
            {tx_req, asleep, tag_off, test_mode}, 0);

        // R2 R3 R4 sweep
        for (int sel = 0; sel < 8; sel++) begin
            for (int si = 0; si < 3; si++) begin
                start(seeds[si], sel, 1'b1, 1'b1, 1'b0, 1'b0, t0);
                e = cur_v() + 2;
                wait_req(t0, n);
                chk(n == e, (si == 0) ? "R4 zero seed first delay" : "R2 first delay", n, e);
                for (int k = 0; k < 3; k++) begin
                    done_edge(t0);
                    chk(!tx_req, "R3 request drops on done", tx_req, 0);
                    e = cur_v() + ACK_WIN + 2;
                    wait_req(t0, n);
                    chk(n == e, "R3 next delay", n, e);
                end
            end
        end

        // R11 hold, R10 mute during transmit
        start(16'h1234, 1, 1'b1, 1'b1, 1'b0, 1'b0, t0);
        wait_req(t0, n);
        mute_evt = 1'b1;
        @(negedge clk);
        mute_evt = 1'b0;
        repeat (4) @(negedge clk);
        chk(tx_req == 1'b1, "R11 request held", tx_req, 1);
        chk(asleep == 1'b0, "R10 mute ignored in transmit", asleep, 0);

        // R8 mute in listen window
        done_edge(t0);
        mute_evt = 1'b1;
        @(negedge clk);
        mute_evt = 1'b0;
        chk(asleep == 1'b1, "R8 asleep after mute", asleep, 1);
        e = cur_v() + SLEEP_LEN + 3;
        wait_req(t0, n);
        chk(n == e, "R8 sleep delay", n, e);

        // R9 restart by second mute
        done_edge(t0);
        mute_evt = 1'b1;
        @(negedge clk);
        mute_evt = 1'b0;
        repeat (5) @(negedge clk);
        mute_evt = 1'b1;
        @(negedge clk);
        mute_evt = 1'b0;
        e = cur_v() + SLEEP_LEN + 5 + 4;
        wait_req(t0, n);
        chk(n == e, "R9 mute restarts sleep", n, e);

        // R9 wake-up ends sleep
        done_edge(t0);
        mute_evt = 1'b1;
        @(negedge clk);
        mute_evt = 1'b0;
        repeat (5) @(negedge clk);
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
        chk(asleep == 1'b0, "R9 wake clears sleep", asleep, 0);
        e = cur_v() + 5 + 4;
        wait_req(t0, n);
        chk(n == e, "R9 wake delay", n, e);

        // R10 mute disabled
        start(16'h0BEE, 2, 1'b1, 1'b0, 1'b0, 1'b0, t0);
        wait_req(t0, n);
        done_edge(t0);
        mute_evt = 1'b1;
        @(negedge clk);
        mute_evt = 1'b0;
        chk(asleep == 1'b0, "R10 mute disabled no sleep", asleep, 0);
        e = cur_v() + ACK_WIN + 2;
        wait_req(t0, n);
        chk(n == e, "R10 mute disabled delay", n, e);

        // R10 ack disabled
        start(16'h1234, 2, 1'b0, 1'b1, 1'b0, 1'b0, t0);
        wait_req(t0, n);
        done_edge(t0);
        ack_evt = 1'b1;
        @(negedge clk);
        ack_evt = 1'b0;
        e = cur_v() + ACK_WIN + 2;
        wait_req(t0, n);
        chk(n == e, "R10 ack disabled delay", n, e);

        // R6 slow-down
        start(16'h1234, 2, 1'b1, 1'b1, 1'b0, 1'b0, t0);
        wait_req(t0, n);
        done_edge(t0);
        ack_evt = 1'b1;
        @(negedge clk);
        ack_evt = 1'b0;
        for (int k = 0; k < 3; k++) begin
            if (k > 0) done_edge(t0);
            e = 8 * cur_v() + ACK_WIN + 2;
            wait_req(t0, n);
            chk(n == e, "R6 slowed delay", n, e);
        end

        // R7 switch-off
        start(16'h5A5A, 0, 1'b1, 1'b1, 1'b1, 1'b0, t0);
        wait_req(t0, n);
        done_edge(t0);
        ack_evt = 1'b1;
        @(negedge clk);
        ack_evt = 1'b0;
        chk(tag_off == 1'b1, "R7 tag switched off", tag_off, 1);
        t0 = cyc;
        wait_req(t0, n);
        e = 200;
        while ((cyc - t0) < e && !tx_req) @(negedge clk);
        chk(!tx_req && tag_off, "R7 no request after off", tx_req, 0);

        // R5 test mode
        start(16'h1234, 0, 1'b1, 1'b1, 1'b0, 1'b1, t0);
        @(negedge clk);
        chk(test_mode == 1'b1, "R5 test mode entered", test_mode, 1);
        n = 0;
        repeat (100) begin
            @(negedge clk);
            if (tx_req) n++;
        end
        chk(n == 0, "R5 no request in test mode", n, 0);

        fin = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, errs);
        $finish;
    end

endmodule